// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Hit Qualifier

This block decides whether a raw comparator hit should become a debug event. An address or data-access comparison happens upstream and arrives as one hit bit per breakpoint and per watchpoint. For each hit the block checks that comparator's control word against the current exception level, the security state and a global debug enable. It also checks an optional link to a context-aware breakpoint, which compares the current context ID against its value register. All comparators are scanned on every access strobe, and the qualified results are ORed into one registered event output.

Software-visible state is a small bank of registers written through a simple write port. The bank holds one global enable bit, a control word and a 32-bit value per breakpoint, and a control word per watchpoint. The number of breakpoints, watchpoints and context-aware breakpoints are parameters. The context-aware breakpoints are always the highest-numbered ones.

Top module: `dbg_hit_qualifier`

## Requirements
- R1: After reset the global enable and every control and value register read as zero, so no access produces an event, and `dbg_event` is low while reset is held.
- R2: A write with `wr_en` high loads `wr_data` into the register picked by `wr_kind` (0 global control, 1 breakpoint control, 2 breakpoint value, 3 watchpoint control) and `wr_idx`. An access in the same cycle still uses the old contents, and accesses from the next cycle on use the new contents.
- R3: `dbg_event` is high in the cycle after an `acc_valid` strobe exactly when at least one hit comparator qualifies. It is low after a cycle without a strobe, whatever the hit inputs are.
- R4: No comparator qualifies while bit 15 of the global control register is 0.
- R5: A comparator qualifies only if bit 0 (enable) of its control word is 1.
- R6: Control bits 15:14 select the security state. A value of 0 matches either state, 1 or 3 match only the non-secure state, and 2 matches only the secure state.
- R7: At level 0 control bit 2 must be 1, at level 1 control bit 1 must be 1, and at levels 2 and 3 control bit 13 must be 1.
- R8: For a watchpoint, an access flagged unprivileged (`acc_unpriv`) is judged at level 0 for R7, whatever `cur_el` is. Breakpoints ignore the flag.
- R9: When control bit 20 is 1 the comparator is linked to the breakpoint numbered by bits 19:16. If that number is not among the context-aware breakpoints (from NUM_BP-NUM_CTX to NUM_BP-1), the comparator never qualifies.
- R10: A linked comparator qualifies only if the target breakpoint has enable bit 0 set and type bits 23:20 equal to 3. Every other type, including reserved codes, gives no event.
- R11: A linked comparator qualifies only if `ctx_id` equals the target's 32-bit value register and the true `cur_el` is 0 or 1. The unprivileged flag does not lift this restriction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register class selector (see R2) |
| wr_idx | input | 4 | Comparator number for the write |
| wr_data | input | 32 | Write data |
| acc_valid | input | 1 | Access strobe; hit and context inputs are valid |
| bp_hit | input | NUM_BP | Raw breakpoint address hits |
| wp_hit | input | NUM_WP | Raw watchpoint access hits |
| cur_el | input | 2 | Current exception level |
| cur_secure | input | 1 | Current security state, 1 = secure |
| acc_unpriv | input | 1 | Access comes from an unprivileged load/store |
| ctx_id | input | 32 | Current context ID |
| dbg_event | output | 1 | Qualified debug event, one cycle after the strobe |

## Verification
The event is registered once, so the result for an access strobed in cycle N is due in cycle N+1. The bench drives each access on a falling edge and reads `dbg_event` on the next falling edge, after exactly one rising edge. Register writes take effect at the rising edge that samples them, so the bench starts each dependent access only on the falling edge after the write. One deliberate case overlaps a write and an access in the same cycle and expects the old contents to apply.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;

  // breakpoint type code that performs a context-ID comparison
  localparam logic [3:0] CTX_MATCH_TYPE = 4'd3;

  typedef enum logic [1:0] {
    REG_GLOBAL  = 2'd0,
    REG_BP_CTRL = 2'd1,
    REG_BP_VAL  = 2'd2,
    REG_WP_CTRL = 2'd3
  } reg_kind_e;

  // fields of a control word that the qualifier actually consumes
  typedef struct packed {
    logic [3:0] lnk_num;
    logic [1:0] sec;
    logic       high;
    logic [1:0] priv;
    logic       en;
    logic       linked;
  } cmp_ctl_t;

  function automatic cmp_ctl_t decode_ctl(input logic [DATA_W-1:0] w);
    cmp_ctl_t c;
    c.en      = w[0];
    c.priv    = w[2:1];
    c.high    = w[13];
    c.sec     = w[15:14];
    c.lnk_num = w[19:16];
    c.linked  = w[20];
    return c;
  endfunction

endpackage

// File: rtl/dbgm_regbank.sv
module dbgm_regbank
  import dbgm_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [1:0]                     wr_kind,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  output logic                           glb_en,
  output cmp_ctl_t [NUM_BP-1:0]          bp_ctl,
  output logic [NUM_BP-1:0][2:0]         bp_typ_hi,
  output logic [NUM_BP-1:0][DATA_W-1:0]  bp_val,
  output cmp_ctl_t [NUM_WP-1:0]          wp_ctl
);

  logic glb_we;
  logic glb_q;

  assign glb_we = wr_en && (wr_kind == REG_GLOBAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_q <= 1'b0;
    else if (glb_we) glb_q <= wr_data[15];
  end

  assign glb_en = glb_q;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic                 ctl_we;
    logic                 val_we;
    cmp_ctl_t             ctl_q;
    logic [2:0]           typ_q;
    logic [DATA_W-1:0]    val_q;

    assign ctl_we = wr_en && (wr_kind == REG_BP_CTRL) && (wr_idx == IDX_W'(i));
    assign val_we = wr_en && (wr_kind == REG_BP_VAL)  && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= '0;
        typ_q <= '0;
      end else if (ctl_we) begin
        ctl_q <= decode_ctl(wr_data);
        typ_q <= wr_data[23:21];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (val_we) val_q <= wr_data;
    end

    assign bp_ctl[i]    = ctl_q;
    assign bp_typ_hi[i] = typ_q;
    assign bp_val[i]    = val_q;
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    logic     ctl_we;
    cmp_ctl_t ctl_q;

    assign ctl_we = wr_en && (wr_kind == REG_WP_CTRL) && (wr_idx == IDX_W'(j));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= decode_ctl(wr_data);
    end

    assign wp_ctl[j] = ctl_q;
  end

endmodule

// File: rtl/dbgm_link.sv
module dbgm_link
  import dbgm_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_CTX = 2
) (
  input  logic [IDX_W-1:0]  lnk_num,
  input  logic [NUM_BP-1:0] ctx_ok,
  output logic              link_ok
);

  localparam int FIRST_CTX = NUM_BP - NUM_CTX;

  logic in_range;
  logic sel;

  always_comb begin
    in_range = (int'(lnk_num) < NUM_BP) && (int'(lnk_num) >= FIRST_CTX);
    sel      = 1'b0;
    for (int i = 0; i < NUM_BP; i++) begin
      if (lnk_num == IDX_W'(i)) sel = ctx_ok[i];
    end
    link_ok = in_range && sel;
  end

endmodule

// File: rtl/dbgm_qual.sv
module dbgm_qual
  import dbgm_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_CTX = 2,
  parameter bit IS_WP   = 1'b0
) (
  input  logic              hit,
  input  cmp_ctl_t          ctl,
  input  logic [1:0]        cur_el,
  input  logic              cur_secure,
  input  logic              acc_unpriv,
  input  logic [NUM_BP-1:0] ctx_ok,
  output logic              qual
);

  logic [1:0] eff_el;
  logic       sec_ok;
  logic       lvl_ok;
  logic       link_ok;

  dbgm_link #(
    .NUM_BP  (NUM_BP),
    .NUM_CTX (NUM_CTX)
  ) u_link (
    .lnk_num (ctl.lnk_num),
    .ctx_ok  (ctx_ok),
    .link_ok (link_ok)
  );

  always_comb begin
    // unprivileged load/store is judged as level 0 on watchpoints only
    eff_el = (IS_WP && acc_unpriv) ? 2'd0 : cur_el;

    case (ctl.sec)
      2'd0:    sec_ok = 1'b1;
      2'd2:    sec_ok = cur_secure;
      default: sec_ok = !cur_secure;
    endcase

    case (eff_el)
      2'd0:    lvl_ok = ctl.priv[1];
      2'd1:    lvl_ok = ctl.priv[0];
      default: lvl_ok = ctl.high;
    endcase

    qual = hit && ctl.en && sec_ok && lvl_ok && (!ctl.linked || link_ok);
  end

endmodule

// File: rtl/dbg_hit_qualifier.sv
module dbg_hit_qualifier
  import dbgm_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_WP  = 2,
  parameter int NUM_CTX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [3:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              acc_valid,
  input  logic [NUM_BP-1:0] bp_hit,
  input  logic [NUM_WP-1:0] wp_hit,
  input  logic [1:0]        cur_el,
  input  logic              cur_secure,
  input  logic              acc_unpriv,
  input  logic [31:0]       ctx_id,
  output logic              dbg_event
);

  logic                          glb_en;
  cmp_ctl_t [NUM_BP-1:0]         bp_ctl;
  logic [NUM_BP-1:0][2:0]        bp_typ_hi;
  logic [NUM_BP-1:0][DATA_W-1:0] bp_val;
  cmp_ctl_t [NUM_WP-1:0]         wp_ctl;

  logic                          ctx_el_ok;
  logic [NUM_BP-1:0]             ctx_ok;
  logic [NUM_BP-1:0]             bp_qual;
  logic [NUM_WP-1:0]             wp_qual;
  logic                          ev_next;
  logic                          ev_q;

  dbgm_regbank #(
    .NUM_BP (NUM_BP),
    .NUM_WP (NUM_WP)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_kind   (wr_kind),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .glb_en    (glb_en),
    .bp_ctl    (bp_ctl),
    .bp_typ_hi (bp_typ_hi),
    .bp_val    (bp_val),
    .wp_ctl    (wp_ctl)
  );

  // context comparisons are shared by every comparator that links to them
  assign ctx_el_ok = (cur_el <= 2'd1);

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    assign ctx_ok[i] = ctx_el_ok && bp_ctl[i].en
                    && ({bp_typ_hi[i], bp_ctl[i].linked} == CTX_MATCH_TYPE)
                    && (bp_val[i] == ctx_id);

    dbgm_qual #(
      .NUM_BP  (NUM_BP),
      .NUM_CTX (NUM_CTX),
      .IS_WP   (1'b0)
    ) u_q (
      .hit        (bp_hit[i]),
      .ctl        (bp_ctl[i]),
      .cur_el     (cur_el),
      .cur_secure (cur_secure),
      .acc_unpriv (acc_unpriv),
      .ctx_ok     (ctx_ok),
      .qual       (bp_qual[i])
    );
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    dbgm_qual #(
      .NUM_BP  (NUM_BP),
      .NUM_CTX (NUM_CTX),
      .IS_WP   (1'b1)
    ) u_q (
      .hit        (wp_hit[j]),
      .ctl        (wp_ctl[j]),
      .cur_el     (cur_el),
      .cur_secure (cur_secure),
      .acc_unpriv (acc_unpriv),
      .ctx_ok     (ctx_ok),
      .qual       (wp_qual[j])
    );
  end

  always_comb begin
    ev_next = acc_valid && glb_en && (|{bp_qual, wp_qual});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= 1'b0;
    else        ev_q <= ev_next;
  end

  assign dbg_event = ev_q;

endmodule

// File: rtl/dbgm_chk.sv
module dbgm_chk
  import dbgm_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_kind,
  input logic [31:0]       wr_data,
  input logic              acc_valid,
  input logic [NUM_BP-1:0] bp_hit,
  input logic [NUM_WP-1:0] wp_hit,
  input logic              glb_en,
  input logic              dbg_event
);

  // R3
  event_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(acc_valid));

  // R3
  event_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(|{bp_hit, wp_hit}));

  // R4
  event_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(glb_en));

  // R2
  global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_kind == REG_GLOBAL)) |=> (glb_en == $past(wr_data[15])));

endmodule

bind dbg_hit_qualifier dbgm_chk #(
  .NUM_BP (NUM_BP),
  .NUM_WP (NUM_WP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_kind   (wr_kind),
  .wr_data   (wr_data),
  .acc_valid (acc_valid),
  .bp_hit    (bp_hit),
  .wp_hit    (wp_hit),
  .glb_en    (glb_en),
  .dbg_event (dbg_event)
);

// File: tb/sim_dbg_hit_qualifier.sv
module sim_dbg_hit_qualifier;

  localparam int NB = 4;
  localparam int NW = 2;
  localparam int NC = 2;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_kind;
  logic [3:0]    wr_idx;
  logic [31:0]   wr_data;
  logic          acc_valid;
  logic [NB-1:0] bp_hit;
  logic [NW-1:0] wp_hit;
  logic [1:0]    cur_el;
  logic          cur_secure;
  logic          acc_unpriv;
  logic [31:0]   ctx_id;
  logic          dbg_event;

  int n_chk = 0;
  int n_bad = 0;

  bit          sh_glb;
  logic [31:0] sh_bpc [NB];
  logic [31:0] sh_bpv [NB];
  logic [31:0] sh_wpc [NW];

  dbg_hit_qualifier #(.NUM_BP(NB), .NUM_WP(NW), .NUM_CTX(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .acc_valid(acc_valid), .bp_hit(bp_hit), .wp_hit(wp_hit),
    .cur_el(cur_el), .cur_secure(cur_secure), .acc_unpriv(acc_unpriv),
    .ctx_id(ctx_id), .dbg_event(dbg_event)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  function automatic bit cmp_model(input logic [31:0] c, input bit is_wp, input int el,
                                   input bit sec, input bit up, input logic [31:0] ctx);
    int lvl;
    int sc;
    int tgt;
    logic [31:0] tc;
    if (c[0] == 1'b0) return 1'b0;
    sc = int'(c[15:14]);
    if (sc == 2 && !sec) return 1'b0;
    if ((sc % 2) == 1 && sec) return 1'b0;
    lvl = (is_wp && up) ? 0 : el;
    if (lvl == 0 && !c[2]) return 1'b0;
    if (lvl == 1 && !c[1]) return 1'b0;
    if (lvl >= 2 && !c[13]) return 1'b0;
    if (c[20]) begin
      tgt = int'(c[19:16]);
      if (tgt >= NB || tgt < NB - NC) return 1'b0;
      tc = sh_bpc[tgt];
      if (!tc[0]) return 1'b0;
      if (int'(tc[23:20]) != 3) return 1'b0;
      if (el > 1) return 1'b0;
      if (ctx != sh_bpv[tgt]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit exp_event(input logic [NB-1:0] bh, input logic [NW-1:0] wh,
                                   input int el, input bit sec, input bit up,
                                   input logic [31:0] ctx, input bit stb);
    bit r;
    r = 1'b0;
    if (stb && sh_glb) begin
      for (int i = 0; i < NB; i++)
        if (bh[i] && cmp_model(sh_bpc[i], 1'b0, el, sec, up, ctx)) r = 1'b1;
      for (int j = 0; j < NW; j++)
        if (wh[j] && cmp_model(sh_wpc[j], 1'b1, el, sec, up, ctx)) r = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input logic act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dbg_event=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic shadow_write(input int kind, input int idx, input logic [31:0] d);
    case (kind)
      0: sh_glb = d[15];
      1: if (idx < NB) sh_bpc[idx] = d;
      2: if (idx < NB) sh_bpv[idx] = d;
      default: if (idx < NW) sh_wpc[idx] = d;
    endcase
  endtask

  // caller sits just after a falling edge
  task automatic wr(input int kind, input int idx, input logic [31:0] d);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow_write(kind, idx, d);
  endtask

  task automatic acc(input logic [NB-1:0] bh, input logic [NW-1:0] wh, input int el,
                     input bit sec, input bit up, input logic [31:0] ctx,
                     input bit stb, input string tag);
    bit e;
    e = exp_event(bh, wh, el, sec, up, ctx, stb);
    bp_hit = bh; wp_hit = wh; cur_el = 2'(el); cur_secure = sec;
    acc_unpriv = up; ctx_id = ctx; acc_valid = stb;
    @(negedge clk);
    acc_valid = 1'b0; bp_hit = '0; wp_hit = '0;
    check(dbg_event, e, tag);
  endtask

  function automatic logic [31:0] mk_ctl(input int en, input int pac, input int hmc,
                                         input int ssc, input int lnk, input int typ);
    return 32'(en) | (32'(pac) << 1) | (32'(hmc) << 13) | (32'(ssc) << 14)
         | (32'(lnk) << 16) | (32'(typ) << 20);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_kind = '0; wr_idx = '0; wr_data = '0;
    acc_valid = 1'b0; bp_hit = '0; wp_hit = '0; cur_el = '0; cur_secure = 1'b0;
    acc_unpriv = 1'b0; ctx_id = '0;
    sh_glb = 1'b0;
    for (int i = 0; i < NB; i++) begin sh_bpc[i] = '0; sh_bpv[i] = '0; end
    for (int j = 0; j < NW; j++) sh_wpc[j] = '0;

    repeat (3) @(negedge clk);
    check(dbg_event, 1'b0, "R1 event low in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all-zero state qualifies nothing, even with global enable set
    acc('1, '1, 0, 1'b0, 1'b0, 32'h0, 1'b1, "R1 reset contents");
    wr(0, 0, 32'h0000_8000);
    acc('1, '1, 0, 1'b0, 1'b0, 32'h0, 1'b1, "R1 zero controls");
    for (int el = 0; el < 4; el++)
      acc('1, '1, el, 1'b1, 1'b0, 32'h0, 1'b1, "R1 zero controls all levels");

    // R4: global enable gates everything
    wr(1, 0, mk_ctl(1, 3, 1, 0, 0, 0));
    wr(0, 0, 32'hFFFF_7FFF);
    acc(4'b0001, '0, 1, 1'b0, 1'b0, 32'h0, 1'b1, "R4 global off");
    wr(0, 0, 32'h0000_8000);
    acc(4'b0001, '0, 1, 1'b0, 1'b0, 32'h0, 1'b1, "R4 global on");

    // R3: hit without strobe, strobe without hit
    acc(4'b0001, '0, 1, 1'b0, 1'b0, 32'h0, 1'b0, "R3 no strobe");
    acc(4'b0000, '0, 1, 1'b0, 1'b0, 32'h0, 1'b1, "R3 no hit");

    // R5 R6 R7: sweep of the qualification fields on breakpoint 0
    for (int en = 0; en < 2; en++)
      for (int pac = 0; pac < 4; pac++)
        for (int hmc = 0; hmc < 2; hmc++)
          for (int ssc = 0; ssc < 4; ssc++) begin
            wr(1, 0, mk_ctl(en, pac, hmc, ssc, 0, 0));
            for (int el = 0; el < 4; el++)
              for (int s = 0; s < 2; s++)
                acc(4'b0001, '0, el, s[0], 1'b0, 32'h0, 1'b1, "R5 R6 R7 field sweep");
          end

    // R8: unprivileged access on watchpoint 1 and on a breakpoint
    wr(1, 0, 32'h0);
    for (int pac = 0; pac < 4; pac++)
      for (int hmc = 0; hmc < 2; hmc++) begin
        wr(3, 1, mk_ctl(1, pac, hmc, 0, 0, 0));
        wr(1, 1, mk_ctl(1, pac, hmc, 0, 0, 0));
        for (int el = 0; el < 4; el++)
          for (int up = 0; up < 2; up++) begin
            acc('0, 2'b10, el, 1'b0, up[0], 32'h0, 1'b1, "R8 watchpoint unpriv");
            acc(4'b0010, '0, el, 1'b0, up[0], 32'h0, 1'b1, "R8 breakpoint ignores unpriv");
          end
      end
    wr(3, 1, 32'h0);

    // R9 R11: link number sweep, targets are context-type breakpoints
    for (int i = 1; i < NB; i++) begin
      wr(1, i, mk_ctl(1, 0, 0, 0, 0, 3));
      wr(2, i, 32'hC0DE_0000 + 32'(i));
    end
    for (int lnk = 0; lnk < 16; lnk++) begin
      wr(1, 0, mk_ctl(1, 3, 1, 0, lnk, 1));
      for (int el = 0; el < 4; el++) begin
        acc(4'b0001, '0, el, 1'b0, 1'b0, 32'hC0DE_0000 + 32'(lnk % 4), 1'b1, "R9 R11 link match");
        acc(4'b0001, '0, el, 1'b0, 1'b0, 32'h1234_5678, 1'b1, "R11 link mismatch");
      end
    end

    // R10: target type and enable sweep on link to breakpoint 3
    wr(1, 0, mk_ctl(1, 3, 1, 0, 3, 1));
    for (int en = 0; en < 2; en++)
      for (int t = 0; t < 16; t++) begin
        wr(1, 3, mk_ctl(en, 0, 0, 0, 0, t));
        acc(4'b0001, '0, 1, 1'b0, 1'b0, 32'hC0DE_0003, 1'b1, "R10 target type");
      end

    // R8 R11: linked watchpoint with unprivileged access at higher levels
    wr(1, 0, 32'h0);
    wr(3, 0, mk_ctl(1, 3, 1, 0, 2, 1));
    for (int el = 0; el < 4; el++)
      for (int up = 0; up < 2; up++)
        acc('0, 2'b01, el, 1'b0, up[0], 32'hC0DE_0002, 1'b1, "R8 R11 linked watchpoint");
    wr(3, 0, 32'h0);

    // R3: OR over comparators
    wr(1, 0, mk_ctl(1, 3, 0, 0, 0, 0));
    wr(1, 1, mk_ctl(0, 3, 0, 0, 0, 0));
    acc(4'b0011, '0, 0, 1'b0, 1'b0, 32'h0, 1'b1, "R3 one of two qualifies");
    acc(4'b0010, '0, 0, 1'b0, 1'b0, 32'h0, 1'b1, "R3 only disabled hit");
    acc(4'b0000, 2'b11, 0, 1'b0, 1'b0, 32'h0, 1'b1, "R3 unqualified watchpoints");

    // R2: write and access in the same cycle use the old control word
    begin
      bit e;
      e = exp_event(4'b0001, '0, 0, 1'b0, 1'b0, 32'h0, 1'b1);
      wr_en = 1'b1; wr_kind = 2'd1; wr_idx = 4'd0; wr_data = 32'h0;
      bp_hit = 4'b0001; wp_hit = '0; cur_el = 2'd0; cur_secure = 1'b0;
      acc_unpriv = 1'b0; ctx_id = 32'h0; acc_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; acc_valid = 1'b0; bp_hit = '0;
      shadow_write(1, 0, 32'h0);
      check(dbg_event, e, "R2 same-cycle write uses old value");
    end
    acc(4'b0001, '0, 0, 1'b0, 1'b0, 32'h0, 1'b1, "R2 next cycle uses new value");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule